// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Tracking

This block turns an NRZ serial line into characters. It takes one sample per pulse of a sample enable. The sample rate is set to 1, 16, 32 or 64 samples per bit. Each character has a start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one stop bit. Finished characters go into a three-entry queue. Each entry holds the data byte and two flags, one for parity error and one for framing error. A sticky overrun flag records any character that arrived while the queue was full.

The block also watches for a line break, which is a long low level on the line. A character whose data bits are all zero and whose stop bit is sampled low raises the live `brk` output. The receiver then stops building characters until the line is sampled high. At that point `brk` drops and exactly one null character goes into the queue. Software can read this null and throw it away.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset the queue is empty (`rd_valid` low), and `overrun` and `brk` are low.
- R2: `cfg_div` sets the samples per bit: 0 means x1, 1 means x16, 2 means x32 and 3 means x64. Only cycles with `samp_en` high count as samples.
- R3: In x1 mode, data bit 0 is taken one sample after the sample that first sees the line low. After that, each following sample takes the next bit.
- R4: In x16, x32 and x64 modes, the line is checked again factor/2 samples after the first low sample. If it is high there, the start is dropped and no character is produced. Otherwise every later bit is taken factor samples after the one before it.
- R5: `cfg_len` values 0 to 3 select 5 to 8 data bits. Bits arrive least significant bit first, and unused upper bits of `rd_data` read as zero.
- R6: When `cfg_par_en` is 1, a parity bit follows the data. `rd_perr` is 1 when the data bits and the parity bit together hold an odd count of ones with `cfg_par_odd`=0, or an even count with `cfg_par_odd`=1. When `cfg_par_en` is 0, `rd_perr` is 0.
- R7: Only one stop bit is checked. `rd_ferr` is 1 exactly when that bit is sampled low. A new start bit may follow the stop bit at once.
- R8: A character with all data bits zero and a low stop bit raises `brk` and is not stored.
- R9: `brk` stays high until the first sample that sees the line high, and it falls on that sample.
- R10: When a break ends, exactly one entry with data 0 and `rd_ferr`=0 is stored. Its `rd_perr` is 1 only when parity is enabled and set to odd.
- R11: The queue holds up to 3 entries and returns them in arrival order. `rd_valid` shows that the head is present, and `rd_en` removes it.
- R12: A character that completes while the queue is full, with no read in the same cycle, is dropped and sets `overrun`. `overrun` stays high until `err_clr` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sample enable, one pulse per sample period |
| rxd | input | 1 | Serial receive line, high when idle |
| cfg_div | input | 2 | Samples per bit: 0=x1, 1=x16, 2=x32, 3=x64 |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| err_clr | input | 1 | Clears the overrun flag |
| rd_en | input | 1 | Removes the head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| overrun | output | 1 | Sticky overrun flag |
| brk | output | 1 | Live break status |

## Verification
The bench sends a short low glitch in the oversampled modes. A receiver that skips the mid-bit recheck would produce a false character from it. The bench holds the line low for a long break and checks three things: `brk` must stay high, and only one null entry may appear, without a framing flag, and with a parity flag only for odd parity. A design that pushed the break character itself, or one null per low character time, would leave extra entries in the queue. The bench also sends two frames with no gap between them, which catches a receiver that waits for more than one stop bit. It sends four frames with no reads to check that the fourth is dropped and `overrun` stays set until it is cleared.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DW = 8;
  localparam int SRX_CW = 7;

  typedef struct packed {
    logic [SRX_DW-1:0] data;
    logic              perr;
    logic              ferr;
  } srx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } srx_state_t;

  function automatic logic [SRX_CW-1:0] div_ticks(input logic [1:0] sel);
    case (sel)
      2'd0:    return SRX_CW'(1);
      2'd1:    return SRX_CW'(16);
      2'd2:    return SRX_CW'(32);
      default: return SRX_CW'(64);
    endcase
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxs,
  input  logic [1:0] cfg_div,
  input  logic [1:0] cfg_len,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       push,
  output srx_entry_t push_entry,
  output logic       brk
);
  srx_state_t        state_q, state_n;
  logic [SRX_CW-1:0] ctr_q, ctr_n;
  logic [2:0]        bit_q, bit_n;
  logic [SRX_DW-1:0] data_q, data_n;
  logic              pbit_q, pbit_n;
  logic              brk_q, brk_n;

  logic [SRX_CW-1:0] factor, last, half_m1;
  logic [2:0]        len_m1;
  logic              hit;

  assign factor  = div_ticks(cfg_div);
  assign last    = factor - SRX_CW'(1);
  assign half_m1 = (factor >> 1) - SRX_CW'(1);
  assign len_m1  = {1'b1, cfg_len};
  assign hit     = tick && (ctr_q == last);

  always_comb begin
    state_n    = state_q;
    ctr_n      = ctr_q;
    bit_n      = bit_q;
    data_n     = data_q;
    pbit_n     = pbit_q;
    brk_n      = brk_q;
    push       = 1'b0;
    push_entry = '0;
    case (state_q)
      ST_IDLE: begin
        if (tick && !rxs) begin
          data_n  = '0;
          bit_n   = '0;
          ctr_n   = '0;
          pbit_n  = 1'b0;
          state_n = (factor == SRX_CW'(1)) ? ST_DATA : ST_START;
        end
      end
      ST_START: begin
        if (tick) begin
          if (ctr_q == half_m1) begin
            ctr_n   = '0;
            state_n = rxs ? ST_IDLE : ST_DATA;
          end else begin
            ctr_n = ctr_q + SRX_CW'(1);
          end
        end
      end
      ST_DATA: begin
        if (hit) begin
          ctr_n         = '0;
          data_n[bit_q] = rxs;
          if (bit_q == len_m1) state_n = par_en ? ST_PAR : ST_STOP;
          else                 bit_n   = bit_q + 3'd1;
        end else if (tick) begin
          ctr_n = ctr_q + SRX_CW'(1);
        end
      end
      ST_PAR: begin
        if (hit) begin
          ctr_n   = '0;
          pbit_n  = rxs;
          state_n = ST_STOP;
        end else if (tick) begin
          ctr_n = ctr_q + SRX_CW'(1);
        end
      end
      ST_STOP: begin
        if (hit) begin
          ctr_n = '0;
          if (!rxs && (data_q == '0)) begin
            brk_n   = 1'b1;
            state_n = ST_BRK;
          end else begin
            push            = 1'b1;
            push_entry.data = data_q;
            push_entry.perr = par_en && ((^data_q) ^ pbit_q ^ par_odd);
            push_entry.ferr = !rxs;
            state_n         = ST_IDLE;
          end
        end else if (tick) begin
          ctr_n = ctr_q + SRX_CW'(1);
        end
      end
      ST_BRK: begin
        if (tick && rxs) begin
          brk_n           = 1'b0;
          push            = 1'b1;
          push_entry.data = '0;
          push_entry.perr = par_en && par_odd;
          push_entry.ferr = 1'b0;
          state_n         = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctr_q   <= '0;
      bit_q   <= '0;
      data_q  <= '0;
      pbit_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ctr_q   <= ctr_n;
      bit_q   <= bit_n;
      data_q  <= data_n;
      pbit_q  <= pbit_n;
      brk_q   <= brk_n;
    end
  end

  assign brk = brk_q;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  srx_entry_t push_entry,
  input  logic       pop_req,
  input  logic       err_clr,
  output logic       valid,
  output srx_entry_t head,
  output logic       overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  srx_entry_t    mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ovr_q, ovr_n;
  logic          pop, accept;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    pop    = pop_req && (cnt_q != '0);
    accept = push && ((cnt_q != CW'(DEPTH)) || pop);
    wp_n   = accept ? bump(wp_q) : wp_q;
    rp_n   = pop ? bump(rp_q) : rp_q;
    cnt_n  = cnt_q + CW'(accept) - CW'(pop);
    ovr_n  = err_clr ? 1'b0 : (ovr_q || (push && !accept));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      ovr_q <= ovr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wp_q] <= push_entry;
  end

  assign valid   = (cnt_q != '0);
  assign head    = mem[rp_q];
  assign overrun = ovr_q;
endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
  import srx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              rxd,
  input  logic [1:0]        cfg_div,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              err_clr,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [SRX_DW-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              overrun,
  output logic              brk
);
  logic       rx_s;
  logic       push;
  srx_entry_t push_entry;
  srx_entry_t head;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rx_s)
  );

  srx_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (samp_en),
    .rxs       (rx_s),
    .cfg_div   (cfg_div),
    .cfg_len   (cfg_len),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .push      (push),
    .push_entry(push_entry),
    .brk       (brk)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_entry(push_entry),
    .pop_req   (rd_en),
    .err_clr   (err_clr),
    .valid     (rd_valid),
    .head      (head),
    .overrun   (overrun)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
endmodule

// File: rtl/serial_rx_brk_chk.sv
module serial_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       samp_en,
  input logic       rx_s,
  input logic       brk,
  input logic       overrun,
  input logic       err_clr,
  input logic       rd_valid,
  input logic       rd_en,
  input logic [7:0] rd_data
);
  // R8
  brk_rise_low_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> ($past(samp_en) && !$past(rx_s)));

  // R9
  brk_fall_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk) |-> ($past(samp_en) && $past(rx_s)));

  // R11
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

  // R12
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun);

  // R12
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !overrun);

  // R12
  overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rd_valid));
endmodule

bind serial_rx_brk serial_rx_brk_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .samp_en (samp_en),
  .rx_s    (rx_s),
  .brk     (brk),
  .overrun (overrun),
  .err_clr (err_clr),
  .rd_valid(rd_valid),
  .rd_en   (rd_en),
  .rd_data (rd_data)
);

// File: tb/serial_rx_brk_test.sv
`timescale 1ns/1ps
module serial_rx_brk_test;
  logic       clk;
  logic       rst_n;
  logic       samp_en;
  logic       rxd;
  logic [1:0] cfg_div;
  logic [1:0] cfg_len;
  logic       cfg_par_en;
  logic       cfg_par_odd;
  logic       err_clr;
  logic       rd_en;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_perr;
  logic       rd_ferr;
  logic       overrun;
  logic       brk;

  int n_chk;
  int n_bad;

  serial_rx_brk uut (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
    .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .err_clr(err_clr), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .overrun(overrun), .brk(brk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_en <= 1'b0;
    else        samp_en <= ~samp_en;
  end

  function automatic int fac(input logic [1:0] d);
    case (d)
      2'd0: return 1;
      2'd1: return 16;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic logic [7:0] mask_len(input logic [7:0] d, input logic [1:0] l);
    return d & ((8'd1 << (5 + l)) - 8'd1);
  endfunction

  function automatic logic good_pbit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int nt);
    rxd = v;
    for (int i = 0; i < nt; i++) begin
      do @(negedge clk); while (samp_en !== 1'b1);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par,
                      input logic stop_v, input int gap);
    int f;
    f = fac(cfg_div);
    hold(1'b0, f);
    for (int i = 0; i < 5 + cfg_len; i++) hold(d[i], f);
    if (cfg_par_en) hold(good_pbit(mask_len(d, cfg_len), cfg_par_odd) ^ bad_par, f);
    hold(stop_v, f);
    hold(1'b1, gap);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] ed,
                         input logic ep, input logic ef);
    @(negedge clk);
    chk(rd_valid === 1'b1, req, rd_valid, 1);
    chk(rd_data === ed, req, rd_data, ed);
    chk(rd_perr === ep, req, rd_perr, ep);
    chk(rd_ferr === ef, req, rd_ferr, ef);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       bp, sb;
    int         f;
    void'($urandom(32'd4242));
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; rxd = 1'b1; err_clr = 1'b0; rd_en = 1'b0;
    cfg_div = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_valid === 1'b0, "R1 valid", rd_valid, 0);
    chk(overrun === 1'b0, "R1 overrun", overrun, 0);
    chk(brk === 1'b0, "R1 brk", brk, 0);
    hold(1'b1, 4);

    // R2 R5 basic x16, 8 bits
    send(8'hA5, 1'b0, 1'b1, 32);
    pop_chk("R2 x16 8-bit", 8'hA5, 1'b0, 1'b0);

    // R3 x1 mode, 5 bits, upper bits zero
    cfg_div = 2'd0; cfg_len = 2'd0;
    send(8'hFF, 1'b0, 1'b1, 4);
    pop_chk("R3 x1 5-bit", 8'h1F, 1'b0, 1'b0);

    // R4 short glitch rejected at mid-bit
    cfg_div = 2'd2; cfg_len = 2'd3;
    hold(1'b0, 3);
    hold(1'b1, 96);
    @(negedge clk);
    chk(rd_valid === 1'b0, "R4 glitch", rd_valid, 0);

    // R6 odd parity good and bad
    cfg_div = 2'd1; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    send(8'h3C, 1'b0, 1'b1, 32);
    pop_chk("R6 odd good", 8'h3C, 1'b0, 1'b0);
    send(8'h3C, 1'b1, 1'b1, 32);
    pop_chk("R6 odd bad", 8'h3C, 1'b1, 1'b0);

    // R7 back-to-back with a single stop bit, then a low stop bit
    cfg_par_en = 1'b0;
    send(8'h81, 1'b0, 1'b1, 0);
    send(8'h42, 1'b0, 1'b1, 32);
    pop_chk("R7 first", 8'h81, 1'b0, 1'b0);
    pop_chk("R7 second", 8'h42, 1'b0, 1'b0);
    send(8'h10, 1'b0, 1'b0, 32);
    pop_chk("R7 framing", 8'h10, 1'b0, 1'b1);

    // R8 R9 R10 break with odd parity, x16
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    hold(1'b0, 16 * 20);
    chk(brk === 1'b1, "R8 brk set", brk, 1);
    chk(rd_valid === 1'b0, "R8 break char not stored", rd_valid, 0);
    hold(1'b0, 16 * 10);
    chk(brk === 1'b1, "R9 brk held", brk, 1);
    hold(1'b1, 48);
    chk(brk === 1'b0, "R9 brk cleared", brk, 0);
    pop_chk("R10 null odd", 8'h00, 1'b1, 1'b0);
    @(negedge clk);
    chk(rd_valid === 1'b0, "R10 single null", rd_valid, 0);

    // R10 break with even parity, x1
    cfg_div = 2'd0; cfg_par_odd = 1'b0;
    hold(1'b0, 40);
    chk(brk === 1'b1, "R8 brk x1", brk, 1);
    hold(1'b1, 4);
    pop_chk("R10 null even", 8'h00, 1'b0, 1'b0);

    // R11 R12 overrun: four frames without reads
    cfg_div = 2'd1; cfg_par_en = 1'b0; cfg_len = 2'd3;
    send(8'h11, 1'b0, 1'b1, 32);
    send(8'h22, 1'b0, 1'b1, 32);
    send(8'h33, 1'b0, 1'b1, 32);
    @(negedge clk);
    chk(overrun === 1'b0, "R11 three fit", overrun, 0);
    send(8'h44, 1'b0, 1'b1, 32);
    @(negedge clk);
    chk(overrun === 1'b1, "R12 overrun set", overrun, 1);
    pop_chk("R11 order 1", 8'h11, 1'b0, 1'b0);
    pop_chk("R11 order 2", 8'h22, 1'b0, 1'b0);
    pop_chk("R11 order 3", 8'h33, 1'b0, 1'b0);
    @(negedge clk);
    chk(rd_valid === 1'b0, "R12 fourth dropped", rd_valid, 0);
    chk(overrun === 1'b1, "R12 overrun held", overrun, 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    chk(overrun === 1'b0, "R12 overrun cleared", overrun, 0);

    // Random frames across all modes (R2 R5 R6 R7)
    for (int k = 0; k < 30; k++) begin
      cfg_div     = 2'($urandom_range(0, 3));
      cfg_len     = 2'($urandom_range(0, 3));
      cfg_par_en  = 1'($urandom_range(0, 1));
      cfg_par_odd = 1'($urandom_range(0, 1));
      d  = 8'($urandom_range(0, 255));
      bp = ($urandom_range(0, 3) == 0);
      sb = ($urandom_range(0, 4) != 0);
      if (mask_len(d, cfg_len) == 8'h00) d = d | 8'h01;
      f = fac(cfg_div);
      send(d, bp, sb, 2 * f);
      pop_chk("R5 random", mask_len(d, cfg_len), cfg_par_en & bp, !sb);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule